// File: doc/BRIEF.md
# Edge-Counting Timer Count Control

This block is a 16-bit timer/counter core steered by an 8-bit count control register. A prescale counter advances on qualifying events. When it reaches the programmed prescale limit it returns to zero and the timer counter steps by one. A qualifying event is either every rising edge of the block clock (timer mode) or an edge of one of two asynchronous capture inputs (counter mode). Counter mode can count the rising edge, the falling edge or both edges.

A separate clear function, enabled by one control bit, zeroes both the prescale counter and the timer counter when a chosen edge appears on a chosen capture input. The two capture inputs pass through a two-flop synchroniser before edge detection. Software writes the control register and the prescale limit through a small write port. It reads them back through a registered read port. The two counters are presented directly as outputs.

Top module: `cap_edge_timer`

## Requirements
- R1: After a synchronous reset, the timer counter, the prescale counter, the prescale limit and the control register are all zero, which means timer mode with clearing disabled.
- R2: With the control mode field (bits 1:0) at 0, the prescale counter advances on every clock cycle.
- R3: Each count event advances the prescale counter by one. When an event arrives while the prescale counter is at or above the limit, the prescale counter becomes 0 and the timer counter increments.
- R4: Mode field value 1 counts rising edges of the selected capture input, value 2 counts falling edges, and value 3 counts both edges.
- R5: The input select field (bits 3:2) picks capture input 0 with value 0 and capture input 1 with value 2. Edges on the other input do not count, and the field is ignored while the mode field is 0.
- R6: An input select value of 1 or 3 in counter mode produces no count events.
- R7: With the clear enable bit (bit 4) set, the clear edge field (bits 7:5) zeroes both counters on one event. Value 0 selects the rising edge of capture input 0, 1 its falling edge, 4 the rising edge of capture input 1, and 5 its falling edge.
- R8: While bit 4 is 0, the clear edge field has no effect on either counter.
- R9: Clear edge values 2, 3, 6 and 7 produce no clear, even with bit 4 set.
- R10: When a clear event and a count event occur in the same cycle, both counters read zero afterwards.
- R11: The timer counter wraps from 0xFFFF to 0 and keeps counting.
- R12: A capture input level change takes effect on the counters at the third rising clock edge after it is applied. Inputs are expected to hold each level for at least two clock cycles.
- R13: A write with address 0 loads the control register from the low 8 data bits, and address 1 loads the prescale limit. The read data shows the register at the current address (control zero-extended) one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 1 | Register address: 0 control, 1 prescale limit |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data for the addressed register |
| cap_in | input | 2 | Asynchronous capture inputs 0 and 1 |
| tc_out | output | 16 | Timer counter |
| pc_out | output | 16 | Prescale counter |

## Verification
The assertions assume that the counters change only through count and clear events. They also assume a capture input never changes faster than the synchroniser can resolve, so every applied level is seen as one clean edge. The stimulus therefore holds each capture level for three clock cycles and drives inputs on the falling clock edge. It changes the control register only between test phases. It lowers the prescale limit only while the prescale counter is not above the new limit.

// File: rtl/ect_pkg.sv
`timescale 1ns/1ps
package ect_pkg;

  localparam int CTRL_W = 8;
  localparam int N_CAP  = 2;

  typedef enum logic [1:0] {
    CM_TIMER = 2'd0,
    CM_RISE  = 2'd1,
    CM_FALL  = 2'd2,
    CM_BOTH  = 2'd3
  } cnt_mode_e;

  // Packed MSB first: [7:5] clear edge, [4] clear enable, [3:2] source, [1:0] mode
  typedef struct packed {
    logic [2:0] clr_edge;
    logic       clr_en;
    logic [1:0] src_sel;
    cnt_mode_e  mode;
  } ctrl_t;

endpackage

// File: rtl/ect_sync_edge.sv
`timescale 1ns/1ps
module ect_sync_edge #(
  parameter int N_IN        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] async_in,
  output logic [N_IN-1:0] rise,
  output logic [N_IN-1:0] fall
);

  localparam int CHAIN = SYNC_STAGES + 1;

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[CHAIN-2:0], async_in[g]};
    end

    // chain_q[SYNC_STAGES-1] is the synchronised level, chain_q[SYNC_STAGES] its previous value
    assign rise[g] =  chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    assign fall[g] = ~chain_q[SYNC_STAGES-1] &  chain_q[SYNC_STAGES];
  end

endmodule

// File: rtl/ect_event_sel.sv
`timescale 1ns/1ps
module ect_event_sel
  import ect_pkg::*;
(
  input  ctrl_t            ctrl,
  input  logic [N_CAP-1:0] rise,
  input  logic [N_CAP-1:0] fall,
  output logic             cnt_evt,
  output logic             clr_evt
);

  logic src_ok;
  logic src_rise, src_fall;
  logic clr_ok;
  logic clr_rise, clr_fall;

  // Source encodings with bit 0 set are reserved; bit 1 picks the input.
  always_comb begin
    src_ok   = ~ctrl.src_sel[0];
    src_rise = rise[ctrl.src_sel[1]];
    src_fall = fall[ctrl.src_sel[1]];
    unique case (ctrl.mode)
      CM_TIMER: cnt_evt = 1'b1;
      CM_RISE:  cnt_evt = src_ok & src_rise;
      CM_FALL:  cnt_evt = src_ok & src_fall;
      CM_BOTH:  cnt_evt = src_ok & (src_rise | src_fall);
      default:  cnt_evt = 1'b0;
    endcase
  end

  // Clear encodings with bit 1 set are reserved; bit 2 picks the input, bit 0 the falling edge.
  always_comb begin
    clr_ok   = ctrl.clr_en & ~ctrl.clr_edge[1];
    clr_rise = rise[ctrl.clr_edge[2]];
    clr_fall = fall[ctrl.clr_edge[2]];
    clr_evt  = clr_ok & (ctrl.clr_edge[0] ? clr_fall : clr_rise);
  end

endmodule

// File: rtl/ect_counter.sv
`timescale 1ns/1ps
module ect_counter #(
  parameter int TC_W = 16,
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cnt_evt,
  input  logic            clr_evt,
  input  logic [PC_W-1:0] limit,
  output logic [TC_W-1:0] tc_q,
  output logic [PC_W-1:0] pc_q
);

  logic pc_done;
  assign pc_done = (pc_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr_evt) begin
      tc_q <= '0;
      pc_q <= '0;
    end else if (cnt_evt) begin
      if (pc_done) begin
        pc_q <= '0;
        tc_q <= tc_q + TC_W'(1);
      end else begin
        pc_q <= pc_q + PC_W'(1);
      end
    end
  end

endmodule

// File: rtl/ect_regs.sv
`timescale 1ns/1ps
module ect_regs
  import ect_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic            addr,
  input  logic [PC_W-1:0] wdata,
  output ctrl_t           ctrl_q,
  output logic [PC_W-1:0] limit_q,
  output logic [PC_W-1:0] rdata_q
);

  localparam int PAD_W = PC_W - CTRL_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      limit_q <= '0;
      rdata_q <= '0;
    end else begin
      rdata_q <= addr ? limit_q : {{PAD_W{1'b0}}, ctrl_q};
      if (we) begin
        if (addr) limit_q <= wdata;
        else      ctrl_q  <= ctrl_t'(wdata[CTRL_W-1:0]);
      end
    end
  end

endmodule

// File: rtl/cap_edge_timer.sv
`timescale 1ns/1ps
module cap_edge_timer
  import ect_pkg::*;
#(
  parameter int TC_W        = 16,
  parameter int PC_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [PC_W-1:0]  reg_wdata,
  output logic [PC_W-1:0]  reg_rdata,
  input  logic [N_CAP-1:0] cap_in,
  output logic [TC_W-1:0]  tc_out,
  output logic [PC_W-1:0]  pc_out
);

  ctrl_t            ctrl_q;
  logic [PC_W-1:0]  limit_q;
  logic [N_CAP-1:0] cap_rise, cap_fall;
  logic             cnt_evt, clr_evt;

  ect_regs #(.PC_W(PC_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .ctrl_q  (ctrl_q),
    .limit_q (limit_q),
    .rdata_q (reg_rdata)
  );

  ect_sync_edge #(.N_IN(N_CAP), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (cap_in),
    .rise     (cap_rise),
    .fall     (cap_fall)
  );

  ect_event_sel u_evt (
    .ctrl    (ctrl_q),
    .rise    (cap_rise),
    .fall    (cap_fall),
    .cnt_evt (cnt_evt),
    .clr_evt (clr_evt)
  );

  ect_counter #(.TC_W(TC_W), .PC_W(PC_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .cnt_evt (cnt_evt),
    .clr_evt (clr_evt),
    .limit   (limit_q),
    .tc_q    (tc_out),
    .pc_q    (pc_out)
  );

endmodule

// File: rtl/ect_checker.sv
`timescale 1ns/1ps
module ect_checker
  import ect_pkg::*;
#(
  parameter int TC_W = 16,
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst,
  input ctrl_t           ctrl,
  input logic            clr_evt,
  input logic [TC_W-1:0] tc,
  input logic [PC_W-1:0] pc
);

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (tc == '0 && pc == '0 && ctrl == '0));

  assert_timer_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl.mode == CM_TIMER && !ctrl.clr_en) |=> !$stable({tc, pc}));

  assert_tc_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tc != $past(tc)) |-> (tc == TC_W'($past(tc) + TC_W'(1)) || tc == '0));

  assert_pc_zero_on_tc_R3: assert property (@(posedge clk) disable iff (rst)
    (tc != $past(tc)) |-> (pc == '0));

  assert_reserved_input_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.mode != CM_TIMER && ctrl.src_sel[0] && !ctrl.clr_en) |=> $stable({tc, pc}));

  assert_clear_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !ctrl.clr_en |-> !clr_evt);

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
    clr_evt |=> (tc == '0 && pc == '0));

endmodule

bind cap_edge_timer ect_checker #(.TC_W(TC_W), .PC_W(PC_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ctrl    (ctrl_q),
  .clr_evt (clr_evt),
  .tc      (tc_out),
  .pc      (pc_out)
);

// File: tb/cap_edge_timer_bench.sv
`timescale 1ns/1ps
module cap_edge_timer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  cap_in = 2'b00;
  logic [15:0] tc_out, pc_out;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  cap_edge_timer u_cap_edge_timer (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in),
    .tc_out(tc_out), .pc_out(pc_out)
  );

  // Behavioural reference model
  int       m_tc, m_pc, m_ctrl, m_lim, m_rd;
  bit [1:0] hist[$];

  function automatic bit edge_of(int idx, bit want_fall);
    bit now_v, old_v;
    now_v = hist[2][idx];
    old_v = hist[3][idx];
    return want_fall ? (!now_v && old_v) : (now_v && !old_v);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_tc = 0; m_pc = 0; m_ctrl = 0; m_lim = 0; m_rd = 0;
      hist = {2'b00, 2'b00, 2'b00};
    end else begin
      int  mode, src, cedge;
      bit  cnt, clr;
      hist.push_front(cap_in);
      if (hist.size() > 4) void'(hist.pop_back());
      mode  = m_ctrl % 4;
      src   = (m_ctrl / 4) % 4;
      cedge = (m_ctrl / 32) % 8;
      cnt = 0;
      if (mode == 0) cnt = 1;
      else if (src == 0 || src == 2) begin
        int ix;
        ix = src / 2;
        if (mode == 1) cnt = edge_of(ix, 0);
        if (mode == 2) cnt = edge_of(ix, 1);
        if (mode == 3) cnt = edge_of(ix, 0) || edge_of(ix, 1);
      end
      clr = 0;
      if (((m_ctrl / 16) % 2) == 1) begin
        if (cedge == 0) clr = edge_of(0, 0);
        if (cedge == 1) clr = edge_of(0, 1);
        if (cedge == 4) clr = edge_of(1, 0);
        if (cedge == 5) clr = edge_of(1, 1);
      end
      if (clr) begin
        m_tc = 0; m_pc = 0;
      end else if (cnt) begin
        if (m_pc >= m_lim) begin
          m_pc = 0;
          m_tc = (m_tc + 1) % 65536;
        end else m_pc = m_pc + 1;
      end
      m_rd = reg_addr ? m_lim : m_ctrl;
      if (reg_we) begin
        if (reg_addr) m_lim = reg_wdata;
        else          m_ctrl = reg_wdata % 256;
      end
    end
  end

  task automatic check(string req, int act, int exp, string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cur_req, tc_out, m_tc, "model tc");
      check(cur_req, pc_out, m_pc, "model pc");
      check(cur_req, reg_rdata, m_rd, "model rdata");
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit a, int d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = 16'(d);
    cyc(1);
    reg_we = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic pulse(int idx);
    cap_in[idx] = 1'b1; cyc(3);
    cap_in[idx] = 1'b0; cyc(3);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    int t0;
    cyc(4);
    // R1: reset state
    check("R1", tc_out, 0, "tc in reset");
    check("R1", pc_out, 0, "pc in reset");
    rst = 1'b0;
    cyc(1);
    check("R1", reg_rdata, 0, "control after reset");

    // R2: timer mode counts every clock (limit 0)
    cur_req = "R2";
    t0 = tc_out; cyc(5);
    check("R2", tc_out, t0 + 5, "tc after 5 clocks");

    // R13: limit write and readback
    cur_req = "R13";
    wr(1, 3);
    reg_addr = 1'b1; cyc(2);
    check("R13", reg_rdata, 3, "limit readback");
    reg_addr = 1'b0; cyc(2);
    check("R13", reg_rdata, 0, "control readback");

    // R3: prescale wrap to limit 3
    cur_req = "R3";
    for (int i = 0; i < 8 && pc_out != 3; i++) cyc(1);
    t0 = tc_out; cyc(1);
    check("R3", pc_out, 0, "pc returns to 0 at limit");
    check("R3", tc_out, t0 + 1, "tc steps at limit");
    cyc(2);
    check("R3", pc_out, 2, "pc counts up again");
    wr(1, 0);

    // R12: synchroniser latency, counting rising edges of input 0
    cur_req = "R12";
    wr(0, 8'h01); cyc(2);
    t0 = tc_out;
    cap_in[0] = 1'b1; cyc(2);
    check("R12", tc_out, t0, "no count before third edge");
    cyc(1);
    check("R12", tc_out, t0 + 1, "count at third edge");
    cap_in[0] = 1'b0; cyc(4);

    // R4: rising edges only
    cur_req = "R4";
    t0 = tc_out;
    for (int i = 0; i < 4; i++) pulse(0);
    cyc(3);
    check("R4", tc_out, t0 + 4, "rising edges of input 0");

    // R5: falling edges of input 1 (mode 2, select 2); input 0 ignored
    cur_req = "R5";
    wr(0, 8'h0A); cyc(2);
    t0 = tc_out;
    for (int i = 0; i < 3; i++) pulse(1);
    pulse(0); pulse(0); cyc(3);
    check("R5", tc_out, t0 + 3, "falling edges of input 1 only");

    // R4: both edges
    cur_req = "R4";
    wr(0, 8'h03); cyc(2);
    t0 = tc_out;
    for (int i = 0; i < 3; i++) pulse(0);
    cyc(3);
    check("R4", tc_out, t0 + 6, "both edges of input 0");

    // R5: select field ignored in timer mode
    cur_req = "R5";
    wr(0, 8'h0C); cyc(2);
    t0 = tc_out; cyc(5);
    check("R5", tc_out, t0 + 5, "timer mode with select 3");

    // R6: reserved input selects 1 and 3
    cur_req = "R6";
    wr(0, 8'h05); cyc(3);
    t0 = tc_out;
    pulse(0); pulse(1); cyc(3);
    check("R6", tc_out, t0, "select 1 counts nothing");
    wr(0, 8'h0F); cyc(3);
    pulse(0); pulse(1); cyc(3);
    check("R6", tc_out, t0, "select 3 counts nothing");

    // R7: clear on rising edge of input 1 (clear field 4), count rising of input 0
    cur_req = "R7";
    wr(0, 8'h91); cyc(2);
    pulse(0); pulse(0); cyc(2);
    check("R7", (tc_out != 0) ? 1 : 0, 1, "counted before clear");
    pulse(1); cyc(2);
    check("R7", tc_out, 0, "tc cleared by input 1 rise");
    check("R7", pc_out, 0, "pc cleared by input 1 rise");
    // clear field 5: falling edge of input 1
    wr(0, 8'hB1); cyc(2);
    pulse(0); pulse(0); cyc(2);
    t0 = tc_out;
    cap_in[1] = 1'b1; cyc(4);
    check("R7", tc_out, t0, "rise does not clear with field 5");
    cap_in[1] = 1'b0; cyc(4);
    check("R7", tc_out, 0, "fall clears with field 5");

    // R10: clear on falling input 0 in timer mode collides with a count
    cur_req = "R10";
    wr(0, 8'h30); cyc(2);
    cap_in[0] = 1'b1; cyc(4);
    cap_in[0] = 1'b0; cyc(3);
    check("R10", tc_out, 0, "tc zero after same-cycle clear");
    check("R10", pc_out, 0, "pc zero after same-cycle clear");
    cyc(1);
    check("R10", tc_out, 1, "counting resumes");

    // R8: clear field set but enable off
    cur_req = "R8";
    wr(0, 8'h20); cyc(2);
    t0 = tc_out;
    pulse(0);
    check("R8", tc_out, t0 + 6, "no clear while disabled");

    // R9: reserved clear encodings 2 and 7
    cur_req = "R9";
    wr(0, 8'h51); cyc(2);
    t0 = tc_out;
    pulse(0); pulse(0); pulse(0); cyc(3);
    check("R9", tc_out, t0 + 3, "field 2 never clears");
    wr(0, 8'hF1); cyc(2);
    t0 = tc_out;
    pulse(1); pulse(0); cyc(3);
    check("R9", tc_out, t0 + 1, "field 7 never clears");

    // R11: wrap of the timer counter
    cur_req = "R11";
    wr(0, 8'h00);
    for (int i = 0; i < 70000 && tc_out != 16'hFFFF; i++) cyc(1);
    check("R11", tc_out, 16'hFFFF, "reached top");
    cyc(1);
    check("R11", tc_out, 0, "wrapped to zero");
    cyc(1);
    check("R11", tc_out, 1, "keeps counting");

    finish_run();
  end

endmodule